// File: doc/BRIEF.md
# Cache Line Lockdown Controller

This block keeps the lock state of a small set-associative instruction cache and a small set-associative data cache. Decoded coprocessor maintenance commands arrive on a single command port that carries a CRm field, an opcode_2 field, a write/read flag and a 32-bit operand. The block answers each read command with one data word. It flags commands that are undefined, and commands that target a cache that is disabled.

The two caches lock lines in different ways. The data cache is modal: a one-bit lock mode register decides whether each fill is locked as it is written. The instruction cache locks one line per command. A fetch-and-lock command sends a fill request for the line-aligned address and holds off further commands until the fill acknowledge returns. The lock bit of the chosen way is set on that acknowledge.

For both caches, the victim way is the lowest-numbered way of the set that is not locked. If every way of the set is locked, the fill still happens but nothing is allocated, and a lock-fail pulse is raised. An unlock command clears every lock bit of its cache in a single cycle. Cache storage, tag lookup and memory refill are outside this block and are reached through plain request/acknowledge ports.

Top module: `cache_lockdown_ctrl`

## Requirements
- R1: After reset, the lock mode is 0, no line of either cache is locked, cmd_ready is 1, and ic_fill_req, rd_valid, cmd_err and both lock-fail outputs are 0.
- R2: A write with CRm=0010 and opcode_2=000 loads operand bit 0 into the lock mode and ignores bits 31:1. A read with the same code gives rd_valid=1 with rd_data={31'b0, mode} one cycle after acceptance, with cmd_err=0.
- R3: While the lock mode is 1, a data-cache fill into a set with a free way drives dc_fill_lock=1 in the same cycle, and that way is locked from the next cycle on. While the lock mode is 0, dc_fill_lock is 0 and no lock bit changes.
- R4: For a fill, the reported way is the lowest-numbered unlocked way of the addressed set. fill_alloc is 0 when all ways of that set are locked.
- R5: A write with CRm=0001 and opcode_2=000 (fetch-and-lock) raises ic_fill_req one cycle after acceptance. The request carries the operand with its low log2(LINE_BYTES) bits cleared and stays stable until ic_fill_ack. cmd_ready is 0 over that time, and the lock bit of the reported way is set at the acknowledge.
- R6: A write with CRm=0001 and opcode_2=001 clears every instruction-cache lock bit by the next cycle, whatever the operand.
- R7: A write with CRm=0010 and opcode_2=001 clears every data-cache lock bit by the next cycle, whatever the operand, and leaves the lock mode unchanged.
- R8: A lock attempt on a fully locked set raises the matching lock-fail output for exactly one cycle. For the instruction cache this is the cycle after the acknowledge; for the data cache it is the cycle after a fill made with the lock mode at 1.
- R9: A read of any code other than CRm=0010/opcode_2=000, or any command with an undefined CRm/opcode_2 pair, gives cmd_err=1 one cycle after acceptance. A read also gives rd_valid=1 with rd_data=0.
- R10: Fetch-and-lock or instruction unlock while icache_en=0, and data unlock while dcache_en=0, give cmd_err=1, raise no fill request, and change no lock bit.
- R11: A command presented while cmd_ready is 0 is dropped and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_crm | input | 4 | CRm field of the command |
| cmd_op2 | input | 3 | opcode_2 field of the command |
| cmd_write | input | 1 | 1 = write/operation, 0 = read |
| cmd_data | input | 32 | Operand: address or register value |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response word |
| cmd_err | output | 1 | Undefined or disabled-cache command |
| icache_en | input | 1 | Instruction cache enabled |
| dcache_en | input | 1 | Data cache enabled |
| ic_fill_req | output | 1 | Instruction fetch-and-lock fill request |
| ic_fill_addr | output | 32 | Line-aligned fill address |
| ic_fill_way | output | 2 | Way chosen for the fill |
| ic_fill_alloc | output | 1 | A free way exists for the fill |
| ic_fill_ack | input | 1 | Fill completed |
| ic_lock_fail | output | 1 | Instruction lock found no free way |
| dc_fill_valid | input | 1 | Data-cache fill happening this cycle |
| dc_fill_set | input | 4 | Set index of that fill |
| dc_fill_way | output | 2 | Way to replace |
| dc_fill_alloc | output | 1 | A free way exists for the fill |
| dc_fill_lock | output | 1 | The filled line becomes locked |
| dc_lock_fail | output | 1 | Data lock found no free way |

## Verification
On every cycle, the embedded assertions check the following. The victim way is never a locked way, and a full set is reported only when every way is locked. An unlock leaves an empty lock array. A pending fill request keeps its address aligned and stable. The lock mode cannot move while a fetch is outstanding. Read responses never carry data in bits 31:1. Other behaviours are only visible through command sequences, and only the bench scenarios show them: which way a later fill takes after a series of locks and unlocks, that commands to a disabled cache leave the lock state untouched, that a command dropped while busy has no later effect, and the exact cycle of each lock-fail pulse.

// File: rtl/lkdn_pkg.sv
package lkdn_pkg;

    localparam logic [3:0] CRM_ICACHE  = 4'b0001;
    localparam logic [3:0] CRM_DCACHE  = 4'b0010;
    localparam logic [2:0] OP2_PRIMARY = 3'b000;
    localparam logic [2:0] OP2_UNLOCK  = 3'b001;

    typedef enum logic [2:0] {
        LK_NONE,
        LK_IC_FETCH,
        LK_IC_UNLOCK,
        LK_DC_MODE_RD,
        LK_DC_MODE_WR,
        LK_DC_UNLOCK
    } lk_op_e;

    typedef struct packed {
        lk_op_e op;
        logic   rd;
        logic   err;
    } lk_cmd_t;

    function automatic lk_cmd_t lk_decode(
        input logic [3:0] crm,
        input logic [2:0] op2,
        input logic       wr,
        input logic       ic_en,
        input logic       dc_en
    );
        lk_cmd_t c;
        c.op  = LK_NONE;
        c.rd  = !wr;
        c.err = 1'b1;
        if (crm == CRM_ICACHE && wr) begin
            if (op2 == OP2_PRIMARY && ic_en) begin
                c.op = LK_IC_FETCH; c.err = 1'b0;
            end else if (op2 == OP2_UNLOCK && ic_en) begin
                c.op = LK_IC_UNLOCK; c.err = 1'b0;
            end
        end else if (crm == CRM_DCACHE) begin
            if (op2 == OP2_PRIMARY) begin
                c.op  = wr ? LK_DC_MODE_WR : LK_DC_MODE_RD;
                c.err = 1'b0;
            end else if (op2 == OP2_UNLOCK && wr && dc_en) begin
                c.op = LK_DC_UNLOCK; c.err = 1'b0;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/lkdn_cmd_decode.sv
module lkdn_cmd_decode
    import lkdn_pkg::*;
(
    input  logic       accept,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic       wr,
    input  logic       ic_en,
    input  logic       dc_en,
    output lk_cmd_t    cmd
);

    lk_cmd_t raw;

    always_comb begin
        raw = lk_decode(crm, op2, wr, ic_en, dc_en);
        cmd = raw;
        if (!accept) begin
            cmd.op  = LK_NONE;
            cmd.rd  = 1'b0;
            cmd.err = 1'b0;
        end
    end

    always_comb begin
        if (cmd.err) begin
            assert (cmd.op == LK_NONE) else $error("AST_ERR_NO_OP"); // R10
        end
    end

endmodule

// File: rtl/lkdn_lock_array.sv
module lkdn_lock_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int SET_W = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             set_en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAY_W-1:0] set_way,
    input  logic [SET_W-1:0] q_idx,
    output logic [WAY_W-1:0] q_way,
    output logic             q_free
);

    logic [SETS-1:0][WAYS-1:0] lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else if (clr_all) begin
            lock_q <= '0;
        end else if (set_en) begin
            lock_q[set_idx][set_way] <= 1'b1;
        end
    end

    always_comb begin
        q_free = 1'b0;
        q_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!lock_q[q_idx][w]) begin
                q_free = 1'b1;
                q_way  = WAY_W'(w);
            end
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (lock_q == '0)); // R6
    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        q_free |-> !lock_q[q_idx][q_way]); // R4
    AST_FULL_SET_ONLY: assert property (@(posedge clk) disable iff (rst)
        !q_free |-> (&lock_q[q_idx])); // R4
    AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_all) |=> lock_q[$past(set_idx)][$past(set_way)]); // R3

endmodule

// File: rtl/cache_lockdown_ctrl.sv
module cache_lockdown_ctrl
    import lkdn_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int IC_SETS    = 16,
    parameter int IC_WAYS    = 4,
    parameter int DC_SETS    = 16,
    parameter int DC_WAYS    = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IC_SET_W  = (IC_SETS > 1) ? $clog2(IC_SETS) : 1,
    localparam int IC_WAY_W  = (IC_WAYS > 1) ? $clog2(IC_WAYS) : 1,
    localparam int DC_SET_W  = (DC_SETS > 1) ? $clog2(DC_SETS) : 1,
    localparam int DC_WAY_W  = (DC_WAYS > 1) ? $clog2(DC_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_crm,
    input  logic [2:0]          cmd_op2,
    input  logic                cmd_write,
    input  logic [ADDR_W-1:0]   cmd_data,
    output logic                cmd_ready,
    output logic                rd_valid,
    output logic [ADDR_W-1:0]   rd_data,
    output logic                cmd_err,
    input  logic                icache_en,
    input  logic                dcache_en,
    output logic                ic_fill_req,
    output logic [ADDR_W-1:0]   ic_fill_addr,
    output logic [IC_WAY_W-1:0] ic_fill_way,
    output logic                ic_fill_alloc,
    input  logic                ic_fill_ack,
    output logic                ic_lock_fail,
    input  logic                dc_fill_valid,
    input  logic [DC_SET_W-1:0] dc_fill_set,
    output logic [DC_WAY_W-1:0] dc_fill_way,
    output logic                dc_fill_alloc,
    output logic                dc_fill_lock
    ,output logic               dc_lock_fail
);

    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

    lk_cmd_t             cmd;
    logic                accept;
    logic                busy_q;
    logic                lock_mode_q;
    logic [ADDR_W-1:0]   req_addr_q;
    logic [IC_WAY_W-1:0] req_way_q;
    logic                req_alloc_q;
    logic                rd_valid_q;
    logic [ADDR_W-1:0]   rd_data_q;
    logic                err_q;
    logic                ic_fail_q;
    logic                dc_fail_q;
    logic                fill_done;

    logic [IC_WAY_W-1:0] ic_q_way;
    logic                ic_q_free;
    logic [DC_WAY_W-1:0] dc_q_way;
    logic                dc_q_free;

    assign accept    = cmd_valid && !busy_q;
    assign fill_done = busy_q && ic_fill_ack;

    lkdn_cmd_decode u_decode (
        .accept (accept),
        .crm    (cmd_crm),
        .op2    (cmd_op2),
        .wr     (cmd_write),
        .ic_en  (icache_en),
        .dc_en  (dcache_en),
        .cmd    (cmd)
    );

    lkdn_lock_array #(
        .SETS  (IC_SETS),
        .WAYS  (IC_WAYS),
        .SET_W (IC_SET_W),
        .WAY_W (IC_WAY_W)
    ) u_ic_locks (
        .clk     (clk),
        .rst     (rst),
        .clr_all (cmd.op == LK_IC_UNLOCK),
        .set_en  (fill_done && req_alloc_q),
        .set_idx (req_addr_q[OFF_W +: IC_SET_W]),
        .set_way (req_way_q),
        .q_idx   (cmd_data[OFF_W +: IC_SET_W]),
        .q_way   (ic_q_way),
        .q_free  (ic_q_free)
    );

    lkdn_lock_array #(
        .SETS  (DC_SETS),
        .WAYS  (DC_WAYS),
        .SET_W (DC_SET_W),
        .WAY_W (DC_WAY_W)
    ) u_dc_locks (
        .clk     (clk),
        .rst     (rst),
        .clr_all (cmd.op == LK_DC_UNLOCK),
        .set_en  (dc_fill_lock),
        .set_idx (dc_fill_set),
        .set_way (dc_q_way),
        .q_idx   (dc_fill_set),
        .q_way   (dc_q_way),
        .q_free  (dc_q_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            lock_mode_q <= 1'b0;
            req_addr_q  <= '0;
            req_way_q   <= '0;
            req_alloc_q <= 1'b0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
            err_q       <= 1'b0;
            ic_fail_q   <= 1'b0;
            dc_fail_q   <= 1'b0;
        end else begin
            rd_valid_q <= cmd.rd;
            rd_data_q  <= (cmd.op == LK_DC_MODE_RD) ? ADDR_W'(lock_mode_q) : '0;
            err_q      <= cmd.err;
            ic_fail_q  <= fill_done && !req_alloc_q;
            dc_fail_q  <= dc_fill_valid && lock_mode_q && !dc_q_free;
            if (cmd.op == LK_DC_MODE_WR) begin
                lock_mode_q <= cmd_data[0];
            end
            if (cmd.op == LK_IC_FETCH) begin
                busy_q      <= 1'b1;
                req_addr_q  <= cmd_data & ~OFF_MASK;
                req_way_q   <= ic_q_way;
                req_alloc_q <= ic_q_free;
            end else if (fill_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign cmd_ready     = !busy_q;
    assign rd_valid      = rd_valid_q;
    assign rd_data       = rd_data_q;
    assign cmd_err       = err_q;
    assign ic_fill_req   = busy_q;
    assign ic_fill_addr  = req_addr_q;
    assign ic_fill_way   = req_way_q;
    assign ic_fill_alloc = req_alloc_q;
    assign ic_lock_fail  = ic_fail_q;
    assign dc_fill_way   = dc_q_way;
    assign dc_fill_alloc = dc_q_free;
    assign dc_fill_lock  = dc_fill_valid && lock_mode_q && dc_q_free;
    assign dc_lock_fail  = dc_fail_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (ic_fill_req && !ic_fill_ack) |=> (ic_fill_req && $stable(ic_fill_addr))); // R5
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        ic_fill_req |-> ((ic_fill_addr & OFF_MASK) == '0)); // R5
    AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(lock_mode_q)); // R11
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[ADDR_W-1:1] == '0)); // R2
    AST_ERR_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && cmd_err) |-> (rd_data == '0)); // R9
    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(ic_fill_req) |-> $past(icache_en)); // R10
    AST_DC_FAIL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        dc_lock_fail |-> $past(dc_fill_valid && !dc_fill_alloc)); // R8

endmodule

// File: tb/cache_lockdown_ctrl_tb.sv
module cache_lockdown_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SETS = 16;
    localparam int WAYS = 4;
    localparam int OFF  = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_crm = '0;
    logic [2:0]  cmd_op2 = '0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready, rd_valid, cmd_err;
    logic [31:0] rd_data;
    logic        icache_en = 1'b1;
    logic        dcache_en = 1'b1;
    logic        ic_fill_req, ic_fill_alloc, ic_lock_fail;
    logic [31:0] ic_fill_addr;
    logic [1:0]  ic_fill_way;
    logic        ic_fill_ack = 1'b0;
    logic        dc_fill_valid = 1'b0;
    logic [3:0]  dc_fill_set = '0;
    logic [1:0]  dc_fill_way;
    logic        dc_fill_alloc, dc_fill_lock, dc_lock_fail;

    cache_lockdown_ctrl u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_crm(cmd_crm),
        .cmd_op2(cmd_op2), .cmd_write(cmd_write), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_err(cmd_err), .icache_en(icache_en), .dcache_en(dcache_en),
        .ic_fill_req(ic_fill_req), .ic_fill_addr(ic_fill_addr),
        .ic_fill_way(ic_fill_way), .ic_fill_alloc(ic_fill_alloc),
        .ic_fill_ack(ic_fill_ack), .ic_lock_fail(ic_lock_fail),
        .dc_fill_valid(dc_fill_valid), .dc_fill_set(dc_fill_set),
        .dc_fill_way(dc_fill_way), .dc_fill_alloc(dc_fill_alloc),
        .dc_fill_lock(dc_fill_lock), .dc_lock_fail(dc_lock_fail)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  ic_m [SETS][WAYS];
    bit  dc_m [SETS][WAYS];
    bit  mode_m = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_way(input bit dc, input int s);
        for (int w = 0; w < WAYS; w++) begin
            if (!(dc ? dc_m[s][w] : ic_m[s][w])) return w;
        end
        return -1;
    endfunction

    task automatic send(input logic [3:0] crm, input logic [2:0] op2,
                        input logic wr, input logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_crm = crm; cmd_op2 = op2;
        cmd_write = wr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_mode(input string req);
        send(4'b0010, 3'b000, 1'b0, $urandom);
        check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        check({req, " rd_data"}, rd_data, 32'(mode_m));
        check({req, " err"}, 32'(cmd_err), 32'd0);
    endtask

    task automatic write_mode(input logic [31:0] v);
        send(4'b0010, 3'b000, 1'b1, v);
        mode_m = v[0];
    endtask

    task automatic unlock(input bit dc);
        send(dc ? 4'b0010 : 4'b0001, 3'b001, 1'b1, $urandom);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (dc) dc_m[s][w] = 0; else ic_m[s][w] = 0;
        check(dc ? "R7 unlock err" : "R6 unlock err", 32'(cmd_err), 32'd0);
    endtask

    task automatic dc_fill(input int s);
        int w;
        w = exp_way(1, s);
        @(negedge clk);
        dc_fill_valid = 1'b1; dc_fill_set = 4'(s);
        #1;
        check("R4 dc alloc", 32'(dc_fill_alloc), 32'(w >= 0));
        if (w >= 0) check("R4 dc way", 32'(dc_fill_way), 32'(w));
        check("R3 dc lock", 32'(dc_fill_lock), 32'(mode_m && w >= 0));
        @(negedge clk);
        dc_fill_valid = 1'b0;
        check("R8 dc fail", 32'(dc_lock_fail), 32'(mode_m && w < 0));
        if (mode_m && w >= 0) dc_m[s][w] = 1;
    endtask

    task automatic fetch_lock(input int s, input int waitc, input bit try_busy);
        int w;
        logic [31:0] a;
        bit saved_mode;
        w = exp_way(0, s);
        a = ($urandom << 9) | (32'(s) << OFF) | ($urandom & 32'h1f);
        saved_mode = mode_m;
        send(4'b0001, 3'b000, 1'b1, a);
        check("R5 req", 32'(ic_fill_req), 32'd1);
        check("R5 addr", ic_fill_addr, a & ~32'h1f);
        check("R5 ready", 32'(cmd_ready), 32'd0);
        check("R4 ic alloc", 32'(ic_fill_alloc), 32'(w >= 0));
        if (w >= 0) check("R4 ic way", 32'(ic_fill_way), 32'(w));
        if (try_busy) begin
            cmd_valid = 1'b1; cmd_crm = 4'b0010; cmd_op2 = 3'b000;
            cmd_write = 1'b1; cmd_data = 32'(!mode_m);
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        for (int i = 0; i < waitc; i++) begin
            @(negedge clk);
            check("R5 req held", 32'(ic_fill_req), 32'd1);
        end
        ic_fill_ack = 1'b1;
        @(negedge clk);
        ic_fill_ack = 1'b0;
        check("R5 req drop", 32'(ic_fill_req), 32'd0);
        check("R5 ready back", 32'(cmd_ready), 32'd1);
        check("R8 ic fail", 32'(ic_lock_fail), 32'(w < 0));
        if (w >= 0) ic_m[s][w] = 1;
        if (try_busy) begin
            mode_m = saved_mode;
            read_mode("R11 dropped cmd");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 ready", 32'(cmd_ready), 32'd1);
        check("R1 req", 32'(ic_fill_req), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 err", 32'(cmd_err), 32'd0);
        check("R1 fails", 32'({ic_lock_fail, dc_lock_fail}), 32'd0);
        read_mode("R1 mode");
        dc_fill(3);

        write_mode(32'hFFFF_FFFE);
        read_mode("R2 upper ignored");
        write_mode(32'h0000_0001);
        read_mode("R2 set");

        send(4'b0101, 3'b000, 1'b0, 32'hFFFF_FFFF);
        check("R9 undef rd err", 32'(cmd_err), 32'd1);
        check("R9 undef rd_valid", 32'(rd_valid), 32'd1);
        check("R9 undef data", rd_data, 32'd0);
        send(4'b0001, 3'b001, 1'b0, 32'h0);
        check("R9 unlock read err", 32'(cmd_err), 32'd1);
        check("R9 unlock read data", rd_data, 32'd0);
        send(4'b0010, 3'b011, 1'b1, 32'h1);
        check("R9 bad op2 err", 32'(cmd_err), 32'd1);
        read_mode("R9 bad op2 no effect");

        for (int i = 0; i < 5; i++) dc_fill(5);
        unlock(1);
        read_mode("R7 mode kept");
        dc_fill(5);

        for (int i = 0; i < 5; i++) fetch_lock(7, i, 1'b0);
        dc_fill(7);

        icache_en = 1'b0;
        send(4'b0001, 3'b000, 1'b1, 32'h0000_00E0);
        check("R10 ic lock err", 32'(cmd_err), 32'd1);
        check("R10 no req", 32'(ic_fill_req), 32'd0);
        send(4'b0001, 3'b001, 1'b1, 32'h0);
        check("R10 ic unlock err", 32'(cmd_err), 32'd1);
        icache_en = 1'b1;
        fetch_lock(7, 0, 1'b0);
        unlock(0);
        fetch_lock(7, 1, 1'b1);

        dcache_en = 1'b0;
        send(4'b0010, 3'b001, 1'b1, 32'h0);
        check("R10 dc unlock err", 32'(cmd_err), 32'd1);
        dcache_en = 1'b1;
        dc_fill(5);

        for (int i = 0; i < 400; i++) begin
            int pick;
            pick = int'($urandom % 12);
            if (pick < 6) dc_fill(int'($urandom % 3));
            else if (pick == 6) write_mode($urandom);
            else if (pick == 7) fetch_lock(int'($urandom % 3), int'($urandom % 4), 1'($urandom));
            else if (pick == 8) read_mode("R2 random read");
            else if (pick == 9) fetch_lock(int'($urandom % 3), 0, 1'b0);
            else if (pick == 10) unlock(0);
            else unlock(1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule